// File: doc/BRIEF.md
# Packet Manchester Coding Stage

This block sits between a packet engine and a serial radio front end. On transmit it takes NRZ bits from an upstream source and produces one line chip per chip-rate enable. Bits that belong to the payload or CRC fields go out as Manchester chip pairs. Preamble and sync bits go out unchanged. Every field shares the same chip clock, so the bit rate inside coded fields is half the chip rate. A ready output holds the source on the first chip of each pair, so the source never has to count chips itself.

On receive it takes one chip per chip-rate enable, together with the field indicator for that chip. It returns NRZ bits with a one-cycle valid strobe. Chip pairs inside coded fields are folded back into single bits. A pair whose two chips are equal is reported as a code violation.

Coding is active only when it is enabled and the packet mode bit is set. A request to enable coding together with data whitening is refused: a conflict output goes high and every field passes as NRZ.

Top module: `mcode_stage`

## Requirements
- R1: With coding active, a bit of 1 in a payload or CRC field is sent as chip 1 and then chip 0. A bit of 0 is sent as chip 0 and then chip 1. The field code is 2'b10 for payload and 2'b11 for CRC.
- R2: Bits in preamble (field 2'b00) and sync (field 2'b01) fields are sent as one chip equal to the bit.
- R3: `tx_chip` changes only in the cycle after a `tx_chip_en` pulse and holds at all other times. After reset, `tx_chip`, `rx_valid`, `rx_err` and `rx_viol_flag` are all low.
- R4: Coding is active only when both `cfg_code_en` and `cfg_packet_mode` are high. When it is not active, every field is passed as NRZ in both directions.
- R5: `cfg_conflict` is high exactly when `cfg_code_en` and `cfg_whiten_en` are both high. Coding is then inactive.
- R6: `tx_ready` is low only while the bit presented is in a coded field and its first chip has not yet been sent. The bit presented is consumed at a chip enable while `tx_ready` is high.
- R7: On receive, `rx_valid` pulses in the cycle after a chip enable. In an NRZ field it pulses after every chip, with `rx_bit` equal to that chip. In a coded field it pulses after the second chip of each pair, with `rx_bit` equal to the pair's first chip. A coded pair may straddle the payload-to-CRC boundary.
- R8: A coded pair of 00 or 11 raises `rx_err` together with `rx_valid`, marking that bit invalid. It also sets `rx_viol_flag`, which stays high until a preamble chip is received.
- R9: The receive pair phase restarts at the first coded chip that follows any NRZ chip. A half-received pair is dropped when an NRZ chip arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_code_en | input | 1 | Manchester coding request |
| cfg_whiten_en | input | 1 | Whitening request (mutually exclusive with coding) |
| cfg_packet_mode | input | 1 | Packet mode; coding is allowed only when high |
| cfg_conflict | output | 1 | Coding and whitening both requested; coding refused |
| tx_chip_en | input | 1 | Transmit chip-rate enable |
| tx_field | input | 2 | Field of the presented bit: 0 preamble, 1 sync, 2 payload, 3 CRC |
| tx_bit | input | 1 | NRZ bit presented by the source |
| tx_ready | output | 1 | Presented bit is consumed at the next chip enable |
| tx_chip | output | 1 | Serial line chip |
| rx_chip_en | input | 1 | Receive chip-rate enable |
| rx_field | input | 2 | Field of the incoming chip, same codes as `tx_field` |
| rx_chip | input | 1 | Incoming line chip |
| rx_valid | output | 1 | One-cycle strobe for a decoded bit |
| rx_bit | output | 1 | Decoded NRZ bit |
| rx_err | output | 1 | Decoded bit came from an invalid chip pair |
| rx_viol_flag | output | 1 | Sticky code-violation flag, cleared by a preamble chip |

## Verification
The assertions assume that the transmit source holds `tx_bit` and `tx_field` steady while `tx_ready` is low. They also assume that the configuration inputs change only between packets, never in the middle of a chip pair. The stimulus obeys both rules. It presents a bit together with its field, keeps that bit across both chip enables of a coded pair, and changes the configuration only after a pair has been completed. Receive chips arrive with their field code attached. The stimulus deliberately includes pairs that cross the payload-to-CRC boundary, pairs cut short by a sync chip, and idle cycles between chip enables.

// File: rtl/mcode_stage.sv
module mcode_stage (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_code_en,
  input  logic       cfg_whiten_en,
  input  logic       cfg_packet_mode,
  output logic       cfg_conflict,
  input  logic       tx_chip_en,
  input  logic [1:0] tx_field,
  input  logic       tx_bit,
  output logic       tx_ready,
  output logic       tx_chip,
  input  logic       rx_chip_en,
  input  logic [1:0] rx_field,
  input  logic       rx_chip,
  output logic       rx_valid,
  output logic       rx_bit,
  output logic       rx_err,
  output logic       rx_viol_flag
);
  localparam logic [1:0] FLD_PRE = 2'd0;

  logic code_on, tx_coded, rx_coded;
  logic tx_half, rx_half, rx_first;

  assign cfg_conflict = cfg_code_en & cfg_whiten_en;
  assign code_on      = cfg_code_en & cfg_packet_mode & ~cfg_whiten_en;
  assign tx_coded     = code_on & tx_field[1];
  assign rx_coded     = code_on & rx_field[1];
  assign tx_ready     = ~(tx_coded & ~tx_half);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_chip <= 1'b0;
      tx_half <= 1'b0;
    end else if (tx_chip_en) begin
      tx_chip <= tx_bit ^ (tx_coded & tx_half);
      tx_half <= tx_coded & ~tx_half;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_valid     <= 1'b0;
      rx_bit       <= 1'b0;
      rx_err       <= 1'b0;
      rx_viol_flag <= 1'b0;
      rx_half      <= 1'b0;
      rx_first     <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      rx_err   <= 1'b0;
      if (rx_chip_en) begin
        if (rx_field == FLD_PRE) rx_viol_flag <= 1'b0;
        if (!rx_coded) begin
          rx_valid <= 1'b1;
          rx_bit   <= rx_chip;
          rx_half  <= 1'b0;
        end else if (!rx_half) begin
          rx_first <= rx_chip;
          rx_half  <= 1'b1;
        end else begin
          rx_valid <= 1'b1;
          rx_bit   <= rx_first;
          rx_err   <= (rx_first == rx_chip);
          rx_half  <= 1'b0;
          if (rx_first == rx_chip) rx_viol_flag <= 1'b1;
        end
      end
    end
  end
endmodule

module mcode_stage_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_packet_mode,
  input logic       cfg_conflict,
  input logic       tx_chip_en,
  input logic [1:0] tx_field,
  input logic       tx_bit,
  input logic       tx_ready,
  input logic       tx_chip,
  input logic       tx_coded,
  input logic       tx_half,
  input logic       rx_chip_en,
  input logic       rx_valid,
  input logic       rx_err,
  input logic       rx_viol_flag
);
  AST_PAIR_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_chip_en && tx_coded && tx_half) |=> (tx_chip != $past(tx_chip))); // R1
  AST_NRZ_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_chip_en && !tx_field[1]) |=> (tx_chip == $past(tx_bit))); // R2
  AST_CHIP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_chip_en) |=> $stable(tx_chip)); // R3
  AST_MODE_OFF_NRZ: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_chip_en && !cfg_packet_mode) |=> (tx_chip == $past(tx_bit))); // R4
  AST_CONFLICT_NRZ: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_chip_en && cfg_conflict) |=> (tx_chip == $past(tx_bit))); // R5
  AST_READY_SECOND_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_chip_en && !tx_ready) |=> tx_half); // R6
  AST_READY_NO_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_ready) |-> !cfg_conflict); // R6
  AST_RX_PACE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(rx_chip_en)); // R7
  AST_ERR_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err |-> (rx_valid && rx_viol_flag)); // R8
endmodule

bind mcode_stage mcode_stage_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_packet_mode(cfg_packet_mode),
  .cfg_conflict(cfg_conflict), .tx_chip_en(tx_chip_en), .tx_field(tx_field),
  .tx_bit(tx_bit), .tx_ready(tx_ready), .tx_chip(tx_chip), .tx_coded(tx_coded),
  .tx_half(tx_half), .rx_chip_en(rx_chip_en), .rx_valid(rx_valid),
  .rx_err(rx_err), .rx_viol_flag(rx_viol_flag)
);

// File: tb/mcode_stage_test.sv
module mcode_stage_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, cfg_code_en, cfg_whiten_en, cfg_packet_mode;
  logic tx_chip_en, tx_bit, rx_chip_en, rx_chip;
  logic [1:0] tx_field, rx_field;
  logic cfg_conflict, tx_ready, tx_chip, rx_valid, rx_bit, rx_err, rx_viol_flag;

  mcode_stage uut (.*);

  int checks = 0, fails = 0;
  bit done = 0;
  logic m_chip = 1'b0, m_rxv = 1'b0, m_rxb = 1'b0, m_rxe = 1'b0, m_flag = 1'b0;
  int m_txph = 0;
  bit rxq[$];

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  function automatic bit m_act();
    return cfg_code_en && cfg_packet_mode && !cfg_whiten_en;
  endfunction

  task automatic tick(input logic te, input logic [1:0] tf, input logic tb,
                      input logic re, input logic [1:0] rf, input logic rc,
                      input string req);
    bit ct, cr;
    tx_chip_en = te; tx_field = tf; tx_bit = tb;
    rx_chip_en = re; rx_field = rf; rx_chip = rc;
    ct = m_act() && tf[1];
    #1;
    chk({req, " R6 ready"}, tx_ready, !(ct && m_txph == 0));
    chk("R5 conflict", cfg_conflict, cfg_code_en && cfg_whiten_en);
    if (te) begin
      if (ct) begin
        m_chip = (m_txph == 0) ? tb : ~tb;
        m_txph = 1 - m_txph;
      end else begin
        m_chip = tb;
        m_txph = 0;
      end
    end
    m_rxv = 0; m_rxe = 0;
    if (re) begin
      cr = m_act() && rf[1];
      if (rf == 2'd0) m_flag = 0;
      if (!cr) begin
        rxq.delete();
        m_rxv = 1; m_rxb = rc;
      end else begin
        rxq.push_back(rc);
        if (rxq.size() == 2) begin
          m_rxv = 1; m_rxb = rxq[0];
          m_rxe = (rxq[0] == rxq[1]);
          if (m_rxe) m_flag = 1;
          rxq.delete();
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk({req, " R3 tx chip"}, tx_chip, m_chip);
    chk({req, " R7 rx valid"}, rx_valid, m_rxv);
    if (m_rxv) chk({req, " R7 rx bit"}, rx_bit, m_rxb);
    chk({req, " R8 rx err"}, rx_err, m_rxe);
    chk({req, " R8 flag"}, rx_viol_flag, m_flag);
  endtask

  task automatic tx_send(input logic [1:0] f, input logic b, input string req);
    if (m_act() && f[1]) begin
      tick(1, f, b, 0, 2'd0, 0, req);
      tick(0, f, b, 0, 2'd0, 0, req);
      tick(1, f, b, 0, 2'd0, 0, req);
    end else begin
      tick(1, f, b, 0, 2'd0, 0, req);
    end
  endtask

  task automatic rx_put(input logic [1:0] f, input logic c, input string req);
    tick(0, 2'd0, 0, 1, f, c, req);
  endtask

  task automatic send_packet(input string req);
    logic [7:0] pay;
    pay = 8'hB4;
    for (int i = 0; i < 4; i++) tx_send(2'd0, i[0], "R2 pre");
    for (int i = 0; i < 4; i++) tx_send(2'd1, ~i[1], "R2 sync");
    for (int i = 7; i >= 0; i--) tx_send(2'd2, pay[i], req);
    for (int i = 0; i < 4; i++) tx_send(2'd3, i[0] ^ i[1], req);
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cfg_code_en = 1; cfg_whiten_en = 0; cfg_packet_mode = 1;
    tx_chip_en = 0; tx_field = 0; tx_bit = 0; rx_chip_en = 0; rx_field = 0; rx_chip = 0;
    repeat (3) @(negedge clk);
    chk("R3 reset tx_chip", tx_chip, 0);
    chk("R3 reset rx_valid", rx_valid, 0);
    chk("R3 reset flag", rx_viol_flag, 0);
    rst_n = 1;
    @(negedge clk);

    send_packet("R1 coded");
    tick(0, 2'd0, 1, 0, 2'd0, 0, "R3 idle");
    tick(0, 2'd0, 0, 0, 2'd0, 0, "R3 idle");

    rx_put(2'd0, 1, "R7 pre");
    rx_put(2'd1, 0, "R7 sync");
    rx_put(2'd2, 1, "R7 pair");
    rx_put(2'd2, 0, "R7 pair");
    rx_put(2'd2, 0, "R7 pair");
    rx_put(2'd2, 1, "R7 pair");
    rx_put(2'd2, 1, "R7 straddle");
    rx_put(2'd3, 0, "R7 straddle");
    rx_put(2'd3, 1, "R8 viol11");
    rx_put(2'd3, 1, "R8 viol11");
    rx_put(2'd3, 0, "R8 viol00");
    rx_put(2'd3, 0, "R8 viol00");
    rx_put(2'd3, 0, "R8 sticky");
    rx_put(2'd3, 1, "R8 sticky");
    rx_put(2'd1, 1, "R8 sync keeps flag");
    rx_put(2'd0, 0, "R8 preamble clears");
    rx_put(2'd1, 1, "R9 sync");
    rx_put(2'd2, 1, "R9 half");
    rx_put(2'd1, 0, "R9 drop");
    rx_put(2'd2, 0, "R9 realign");
    rx_put(2'd2, 1, "R9 realign");

    cfg_packet_mode = 0;
    send_packet("R4 mode off");
    rx_put(2'd2, 1, "R4 rx nrz");
    rx_put(2'd2, 1, "R4 rx nrz");
    cfg_packet_mode = 1; cfg_code_en = 0;
    send_packet("R4 code off");
    cfg_code_en = 1; cfg_whiten_en = 1;
    send_packet("R5 conflict");
    rx_put(2'd3, 0, "R5 rx nrz");
    cfg_code_en = 0;
    tx_send(2'd2, 1, "R5 whiten only");
    cfg_code_en = 1; cfg_whiten_en = 0;
    send_packet("R1 again");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule